// File: doc/BRIEF.md
# Paired ADC/DAC Conversion Sequencer

This block takes the place of a processor bus that would otherwise drive an 8-bit parallel ADC and a 12-bit parallel DAC in software. A single `start` pulse launches a run. The run opens with one discarded ADC read, which puts the converter into a known state. It then executes a programmable number of identical 28-cycle frames. In each frame the ADC receives a start-of-conversion strobe, the sequencer waits, then reads the ADC and captures the result. During the same frame the next point of a triangular waveform is sent to the DAC.

With a 60 ns cycle, each strobe is 300 ns wide and a frame lasts 1680 ns, which gives about 595 kHz. The triangle starts at zero at the beginning of each run. It climbs by the step latched at `start` for `RISE_PTS` frames, then descends by the same step for `FALL_PTS` frames, and this pattern repeats. The level is clamped to the 12-bit range. Each captured byte is presented on `sample` with a one-cycle `sample_vld`. When the last frame ends, the block returns to idle with `done` held high.

Frame positions are counted from 0 within each 28-cycle frame:

| Positions | Activity |
|---|---|
| 0 | Idle slot, used as the ADC select lead cycle |
| 1–5 | ADC write strobe |
| 6–10 | Conversion wait |
| 11–15 | ADC read strobe |
| 16–22 | Store and fetch |
| 23–27 | DAC write strobe |

Top module: `convpair_seq`

## Requirements
- R1: After reset, all selects and strobes are high (inactive), `done` and `sample_vld` are 0, and `dac_data` is 0.
- R2: Each strobe (`adc_wr_n`, `adc_rd_n`, `dac_wr_n`) is low for exactly 5 consecutive cycles whenever it is asserted.
- R3: Within a frame, `adc_wr_n` is low at positions 1–5, `adc_rd_n` at 11–15 and `dac_wr_n` at 23–27. This leaves a 5-cycle gap between the end of the ADC write and the start of the ADC read. Frames follow back to back every 28 cycles.
- R4: `adc_cs_n` is low at frame positions 0–6 and 10–16. `dac_cs_n` is low at positions 22–27 and is released together with its strobe. The two selects are never low in the same cycle, and each strobe is low only while its own select is low.
- R5: Accepting `start` produces a 7-cycle dummy read before frame 0. During this read `adc_cs_n` is low for all 7 cycles, `adc_rd_n` is low in cycles 1–5, and `sample_vld` stays 0.
- R6: The byte on `adc_din` during the last read cycle (position 15) appears on `sample`, with `sample_vld` high for exactly the next cycle (position 16).
- R7: Frame k writes level L(k) to the DAC. L(0)=0. L(k+1) is L(k)+step clamped to 4095 if (k mod (RISE_PTS+FALL_PTS)) < RISE_PTS, and otherwise L(k)−step clamped to 0. `dac_data` holds L(k) stable through the DAC write.
- R8: After `frame_total` frames, the block returns to idle and holds `done` high until the next `start`. A `frame_total` of 0 runs only the dummy read.
- R9: A `start` pulse received during a run is ignored, and the run length is unchanged.
- R10: `frame_total` and `wave_step` are sampled only when `start` is accepted; changes during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one 60 ns timing unit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| frame_total | input | 16 | Number of frames in the run |
| wave_step | input | 12 | Triangle increment per frame |
| adc_cs_n | output | 1 | ADC chip select, active low |
| adc_wr_n | output | 1 | ADC start-of-conversion strobe, active low |
| adc_rd_n | output | 1 | ADC read strobe, active low |
| adc_din | input | 8 | ADC parallel result |
| dac_cs_n | output | 1 | DAC chip select, active low |
| dac_wr_n | output | 1 | DAC write strobe, active low |
| dac_data | output | 12 | DAC code |
| sample | output | 8 | Last captured ADC byte |
| sample_vld | output | 1 | One-cycle pulse marking a new `sample` |
| done | output | 1 | Run finished; held until the next start |

## Verification
Runs are tried with several patterns, and each pattern isolates a different behaviour:
- **Zero frames** separates the dummy read from a real frame.
- **A few frames with a small step** exercise the 28-cycle cadence and the frame-to-frame select handover.
- **A large step over many frames** drives the triangle into both clamps, which separates saturating arithmetic from wrapping arithmetic.
- **A run with random input disturbances** shows that only the values latched at `start` matter. During this run `start` is pulsed again, and `frame_total` and `wave_step` are scrambled.

In all runs the ADC byte is random every cycle. Any slip in the capture point therefore shows up as a wrong `sample`. The full default-length run also checks the frame count far from zero.

// File: rtl/convpair_pkg.sv
package convpair_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DUMMY = 2'd1,
    ST_FRAME = 2'd2
  } seq_state_e;

  // True when position p lies in the closed window [lo, hi].
  function automatic logic in_win(input int unsigned p, input int unsigned lo,
                                  input int unsigned hi);
    return (p >= lo) && (p <= hi);
  endfunction

endpackage

// File: rtl/frame_timer.sv
module frame_timer
  import convpair_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int STB_CYC  = 5,
  parameter int WAIT_CYC = 5,
  parameter int XFER_CYC = 7,
  parameter int FRAME_LEN = 1 + 3 * STB_CYC + WAIT_CYC + XFER_CYC,
  parameter int POS_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] frame_total,
  output seq_state_e       state,
  output logic [POS_W-1:0] pos,
  output logic             run_go,
  output logic             done
);

  localparam int PRE_LEN = STB_CYC + 2;
  localparam logic [POS_W-1:0] PRE_LAST   = POS_W'(PRE_LEN - 1);
  localparam logic [POS_W-1:0] FRAME_LAST = POS_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] frm_goal;
  logic [CNT_W-1:0] frm_idx;
  logic             pre_end;
  logic             frm_end;
  logic             last_frame;

  assign run_go     = (state == ST_IDLE) && start;
  assign pre_end    = (state == ST_DUMMY) && (pos == PRE_LAST);
  assign frm_end    = (state == ST_FRAME) && (pos == FRAME_LAST);
  assign last_frame = ({1'b0, frm_idx} + 1'b1) == {1'b0, frm_goal};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pos      <= '0;
      frm_goal <= '0;
      frm_idx  <= '0;
      done     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_DUMMY;
            pos      <= '0;
            frm_goal <= frame_total;
            frm_idx  <= '0;
            done     <= 1'b0;
          end
        end
        ST_DUMMY: begin
          if (pre_end) begin
            pos <= '0;
            if (frm_goal == '0) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state <= ST_FRAME;
            end
          end else begin
            pos <= pos + 1'b1;
          end
        end
        ST_FRAME: begin
          if (frm_end) begin
            pos <= '0;
            if (last_frame) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              frm_idx <= frm_idx + 1'b1;
            end
          end else begin
            pos <= pos + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          pos   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
  import convpair_pkg::*;
#(
  parameter int STB_CYC  = 5,
  parameter int WAIT_CYC = 5,
  parameter int XFER_CYC = 7,
  parameter int POS_W    = 5
) (
  input  seq_state_e       state,
  input  logic [POS_W-1:0] pos,
  output logic             adc_cs_n,
  output logic             adc_wr_n,
  output logic             adc_rd_n,
  output logic             dac_cs_n,
  output logic             dac_wr_n,
  output logic             ev_capture,
  output logic             ev_load
);

  // Frame layout: position 0 is the idle slot and doubles as ADC select lead.
  localparam int W0 = 1;
  localparam int R0 = W0 + STB_CYC + WAIT_CYC;
  localparam int X0 = R0 + STB_CYC;
  localparam int D0 = X0 + XFER_CYC;

  int unsigned p;
  logic        in_frame;
  logic        in_dummy;
  logic        wr_win;
  logic        rd_win;
  logic        dwr_win;
  logic        acs_win;
  logic        dcs_win;

  always_comb begin
    p        = 32'(pos);
    in_frame = (state == ST_FRAME);
    in_dummy = (state == ST_DUMMY);
    wr_win   = in_frame && in_win(p, W0, W0 + STB_CYC - 1);
    rd_win   = (in_frame && in_win(p, R0, R0 + STB_CYC - 1)) ||
               (in_dummy && in_win(p, 1, STB_CYC));
    dwr_win  = in_frame && in_win(p, D0, D0 + STB_CYC - 1);
    acs_win  = in_dummy ||
               (in_frame && (in_win(p, W0 - 1, W0 + STB_CYC) ||
                             in_win(p, R0 - 1, R0 + STB_CYC)));
    dcs_win  = in_frame && in_win(p, D0 - 1, D0 + STB_CYC - 1);
  end

  assign adc_wr_n   = !wr_win;
  assign adc_rd_n   = !rd_win;
  assign dac_wr_n   = !dwr_win;
  assign adc_cs_n   = !acs_win;
  assign dac_cs_n   = !dcs_win;
  assign ev_capture = in_frame && (p == R0 + STB_CYC - 1);
  assign ev_load    = in_frame && (p == X0);

endmodule

// File: rtl/tri_wave.sv
module tri_wave #(
  parameter int DAC_W    = 12,
  parameter int RISE_PTS = 16,
  parameter int FALL_PTS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [DAC_W-1:0] step_in,
  input  logic             advance,
  output logic [DAC_W-1:0] level
);

  localparam int PER  = RISE_PTS + FALL_PTS;
  localparam int PT_W = (PER > 1) ? $clog2(PER) : 1;
  localparam logic [PT_W-1:0] PT_LAST = PT_W'(PER - 1);
  localparam logic [PT_W-1:0] RISE_L  = PT_W'(RISE_PTS);

  function automatic logic [DAC_W-1:0] up_sat(input logic [DAC_W-1:0] a,
                                              input logic [DAC_W-1:0] s);
    logic [DAC_W:0] sum;
    sum = {1'b0, a} + {1'b0, s};
    return sum[DAC_W] ? {DAC_W{1'b1}} : sum[DAC_W-1:0];
  endfunction

  function automatic logic [DAC_W-1:0] down_sat(input logic [DAC_W-1:0] a,
                                                input logic [DAC_W-1:0] s);
    return (s > a) ? '0 : a - s;
  endfunction

  logic [DAC_W-1:0] step_q;
  logic [PT_W-1:0]  pt;
  logic             rising;

  assign rising = (pt < RISE_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level  <= '0;
      step_q <= '0;
      pt     <= '0;
    end else if (clear) begin
      level  <= '0;
      step_q <= step_in;
      pt     <= '0;
    end else if (advance) begin
      level <= rising ? up_sat(level, step_q) : down_sat(level, step_q);
      pt    <= (pt == PT_LAST) ? '0 : pt + 1'b1;
    end
  end

endmodule

// File: rtl/convpair_seq.sv
module convpair_seq
  import convpair_pkg::*;
#(
  parameter int ADC_W    = 8,
  parameter int DAC_W    = 12,
  parameter int CNT_W    = 16,
  parameter int STB_CYC  = 5,
  parameter int WAIT_CYC = 5,
  parameter int XFER_CYC = 7,
  parameter int RISE_PTS = 16,
  parameter int FALL_PTS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] frame_total,
  input  logic [DAC_W-1:0] wave_step,
  output logic             adc_cs_n,
  output logic             adc_wr_n,
  output logic             adc_rd_n,
  input  logic [ADC_W-1:0] adc_din,
  output logic             dac_cs_n,
  output logic             dac_wr_n,
  output logic [DAC_W-1:0] dac_data,
  output logic [ADC_W-1:0] sample,
  output logic             sample_vld,
  output logic             done
);

  localparam int FRAME_LEN = 1 + 3 * STB_CYC + WAIT_CYC + XFER_CYC;
  localparam int POS_W     = $clog2(FRAME_LEN);

  seq_state_e       state;
  logic [POS_W-1:0] pos;
  logic             run_go;
  logic             ev_capture;
  logic             ev_load;
  logic [DAC_W-1:0] wave_level;

  frame_timer #(
    .CNT_W(CNT_W), .STB_CYC(STB_CYC), .WAIT_CYC(WAIT_CYC),
    .XFER_CYC(XFER_CYC), .FRAME_LEN(FRAME_LEN), .POS_W(POS_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_total(frame_total),
    .state(state), .pos(pos), .run_go(run_go), .done(done)
  );

  strobe_decode #(
    .STB_CYC(STB_CYC), .WAIT_CYC(WAIT_CYC), .XFER_CYC(XFER_CYC), .POS_W(POS_W)
  ) u_decode (
    .state(state), .pos(pos),
    .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n),
    .dac_cs_n(dac_cs_n), .dac_wr_n(dac_wr_n),
    .ev_capture(ev_capture), .ev_load(ev_load)
  );

  tri_wave #(
    .DAC_W(DAC_W), .RISE_PTS(RISE_PTS), .FALL_PTS(FALL_PTS)
  ) u_wave (
    .clk(clk), .rst_n(rst_n), .clear(run_go), .step_in(wave_step),
    .advance(ev_load), .level(wave_level)
  );

  // Capture register on the last read cycle; DAC code fetched in the transfer slot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample     <= '0;
      sample_vld <= 1'b0;
      dac_data   <= '0;
    end else begin
      sample_vld <= ev_capture;
      if (ev_capture) sample <= adc_din;
      if (ev_load) dac_data <= wave_level;
    end
  end

endmodule

// File: rtl/convpair_chk.sv
module convpair_chk #(
  parameter int DAC_W   = 12,
  parameter int STB_CYC = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adc_cs_n,
  input logic             adc_wr_n,
  input logic             adc_rd_n,
  input logic             dac_cs_n,
  input logic             dac_wr_n,
  input logic [DAC_W-1:0] dac_data,
  input logic             sample_vld,
  input logic             done
);

  logic [2:0] stb_n;
  assign stb_n = {adc_wr_n, adc_rd_n, dac_wr_n};

  for (genvar g = 0; g < 3; g++) begin : g_width
    logic [7:0] lo_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lo_cnt <= '0;
      else if (!stb_n[g]) lo_cnt <= lo_cnt + 1'b1;
      else lo_cnt <= '0;
    end
    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_n[g] && lo_cnt != 8'd0) |-> (lo_cnt == 8'(STB_CYC))); // R2
    AST_STROBE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_n[g] |-> (lo_cnt < 8'(STB_CYC))); // R2
  end

  AST_SELECT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!adc_cs_n && !dac_cs_n)); // R4
  AST_ADC_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_wr_n || !adc_rd_n) |-> !adc_cs_n); // R4
  AST_DAC_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |-> !dac_cs_n); // R4
  AST_WR_RD_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(!adc_wr_n && !adc_rd_n)); // R3
  AST_VLD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> (adc_rd_n && !$past(adc_rd_n))); // R6
  AST_DAC_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_wr_n && !$past(dac_wr_n)) |-> $stable(dac_data)); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (adc_cs_n && dac_cs_n && !sample_vld)); // R8

endmodule

bind convpair_seq convpair_chk #(.DAC_W(DAC_W), .STB_CYC(STB_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n),
  .adc_rd_n(adc_rd_n), .dac_cs_n(dac_cs_n), .dac_wr_n(dac_wr_n),
  .dac_data(dac_data), .sample_vld(sample_vld), .done(done)
);

// File: tb/test_convpair_seq.sv
`timescale 1ns/1ps
module test_convpair_seq;

  localparam int RISE = 16;
  localparam int FALL = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] frame_total = '0;
  logic [11:0] wave_step = '0;
  logic        adc_cs_n, adc_wr_n, adc_rd_n, dac_cs_n, dac_wr_n;
  logic [7:0]  adc_din = '0;
  logic [11:0] dac_data;
  logic [7:0]  sample;
  logic        sample_vld, done;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  convpair_seq i_convpair_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_total(frame_total),
    .wave_step(wave_step), .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n),
    .adc_rd_n(adc_rd_n), .adc_din(adc_din), .dac_cs_n(dac_cs_n),
    .dac_wr_n(dac_wr_n), .dac_data(dac_data), .sample(sample),
    .sample_vld(sample_vld), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected pin vector {adc_cs_n, adc_wr_n, adc_rd_n, dac_cs_n, dac_wr_n}.
  function automatic int pins_dummy(input int p);
    return {1'b0, 1'b1, !(p >= 1 && p <= 5), 1'b1, 1'b1};
  endfunction

  function automatic int pins_frame(input int p);
    logic acs, dcs;
    acs = (p <= 6) || (p >= 10 && p <= 16);
    dcs = (p >= 22);
    return {!acs, !(p >= 1 && p <= 5), !(p >= 11 && p <= 15), !dcs, !(p >= 23)};
  endfunction

  function automatic int next_level(input int v, input int k, input int s);
    if ((k % (RISE + FALL)) < RISE) return (v + s > 4095) ? 4095 : v + s;
    return (v < s) ? 0 : v - s;
  endfunction

  // One complete run; poke scrambles inputs and re-pulses start mid-run (R9, R10).
  task automatic run(input int n, input int stp, input bit poke);
    int lvl;
    int exp_smp;
    int end_t;
    lvl     = 0;
    exp_smp = 0;
    end_t   = 7 + 28 * n;
    @(negedge clk);
    start = 1'b1; frame_total = 16'(n); wave_step = 12'(stp);
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t <= end_t; t++) begin
      int p;
      int k;
      int pv;
      pv = {adc_cs_n, adc_wr_n, adc_rd_n, dac_cs_n, dac_wr_n};
      if (t == end_t) begin
        chk("R8 done after last frame", int'(done), 1);
        chk("R8 R9 idle pins at end", pv, 5'b11111);
      end else begin
        chk("R8 R9 done low while running", int'(done), 0);
        if (t < 7) begin
          chk("R5 dummy read pins", pv, pins_dummy(t));
          chk("R5 no sample during dummy", int'(sample_vld), 0);
        end else begin
          p = (t - 7) % 28;
          k = (t - 7) / 28;
          chk("R2 R3 R4 frame pins", pv, pins_frame(p));
          chk("R6 sample_vld", int'(sample_vld), (p == 16) ? 1 : 0);
          if (p == 16) chk("R6 captured byte", int'(sample), exp_smp);
          if (p >= 23) chk("R7 R10 dac level", int'(dac_data), lvl);
          if (p == 27) lvl = next_level(lvl, k, stp & 12'hFFF);
        end
      end
      adc_din = 8'($urandom);
      if (t >= 7 && ((t - 7) % 28) == 15) exp_smp = int'(adc_din);
      if (poke) begin
        frame_total = 16'($urandom);
        wave_step   = 12'($urandom);
        start       = (t == 40) || (t == 41);
      end
      @(negedge clk);
    end
    start = 1'b0;
    repeat (3) begin
      chk("R8 done held in idle", int'(done), 1);
      chk("R8 pins idle after run", int'({adc_cs_n, adc_wr_n, adc_rd_n, dac_cs_n, dac_wr_n}), 5'b11111);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0C0D));
    repeat (3) @(negedge clk);
    chk("R1 reset pins", int'({adc_cs_n, adc_wr_n, adc_rd_n, dac_cs_n, dac_wr_n}), 5'b11111);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset sample_vld", int'(sample_vld), 0);
    chk("R1 reset dac_data", int'(dac_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(0, 2, 1'b0);          // R8 zero frames: dummy only
    run(3, 2, 1'b0);          // R3 short run, default step
    run(40, 300, 1'b0);       // R7 hits both clamps
    run(70, 4095, 1'b0);      // R7 full-scale step
    run(12, 9, 1'b1);         // R9 R10 disturbed inputs
    for (int i = 0; i < 5; i++) begin
      run(1 + int'($urandom % 30), int'($urandom % 4096), i[0]);
    end
    run(16'h0682, 2, 1'b0);   // default run length
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule